// File: doc/BRIEF.md
# Asynchronous Memory Bus Timing Controller

This block turns single-word read and write requests from an internal master into timed cycles on an asynchronous external memory bus. Typical targets are a memory-mapped FPGA or a flash device. No bus clock leaves the block. The external device samples on the edges of the active-low strobes, so every edge is placed by counting internal clock cycles.

A 32-bit configuration word is presented with each request and latched when the request is accepted. It sets the following:
- separate setup, strobe and hold lengths for reads and for writes;
- a turnaround gap used when the transfer direction changes;
- a strobe style that narrows chip enable to the strobe phase;
- an option that lets a wait input stretch the strobe phase;
- a data width code.

Read data is captured on the last strobe cycle. The master sees a one-cycle done pulse when the hold phase ends.

Top module: `amc_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dout_en` is low, `req_ready` is high and `rsp_done` is low.
- R2: The configuration word is decoded as follows: bit 31 strobe style, bit 30 wait enable, bits 29:26 write setup, 25:20 write strobe, 19:17 write hold, 16:13 read setup, 12:7 read strobe, 6:4 read hold, 3:2 turnaround, 1:0 width code.
- R3: An access runs a setup phase, then a strobe phase, then a hold phase. A field value N gives N+1 clock cycles, taken from the read fields for reads and from the write fields for writes.
- R4: A turnaround gap of turnaround+1 cycles, with all strobes high, comes before setup only when the access direction differs from the previous access. There is no gap on the first access after reset or when the direction repeats.
- R5: With bit 31 clear, `mem_ce_n` is low through setup, strobe and hold. With bit 31 set, `mem_ce_n` is low only during the strobe phase.
- R6: `mem_oe_n` is low only during a read strobe phase and `mem_we_n` only during a write strobe phase. The two are never low together.
- R7: During a write, `mem_dout_en` is high in setup, strobe and hold, and `mem_addr`/`mem_dout` carry the request. Width code 0 selects an 8-bit bus and drives the upper byte as zero; any other code uses the full 16 bits. `mem_dout_en` stays low for reads.
- R8: Read data is registered from `mem_din` on the last strobe cycle and held on `rsp_rdata`. With width code 0 the upper byte reads as zero.
- R9: `req_ready` is low from acceptance until the access ends. `rsp_done` is a single-cycle pulse in the cycle after the last hold cycle, and `req_ready` is high again in that same cycle.
- R10: With bit 30 set, the strobe phase does not end while `mem_wait` is high, so it lasts the larger of strobe+1 and the number of cycles until wait falls. With bit 30 clear, `mem_wait` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| cfg_word | input | 32 | Timing and mode word, latched on acceptance |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable (read strobe), active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | External address |
| mem_dout | output | DATA_W | External write data |
| mem_dout_en | output | 1 | Drive enable for the data pins |
| mem_din | input | DATA_W | External read data |
| mem_wait | input | 1 | Device wait request |

## Verification
The bench builds the block with its defaults, a 20-bit address and a 16-bit data bus. This allows both width codes to be compared, with the upper byte showing the difference.

The bench sweeps every setup value, every hold value and short, mid and maximum strobe lengths. In each sweep word the read fields differ from the write fields, so a misplaced bit field changes a measured phase length. Each configuration runs write, write, read, read, which exercises the direction-change gap at all four turnaround values next to same-direction back-to-back accesses. Both strobe styles are covered.

The read data pattern is present only while the output enable is low, so a capture taken in the wrong cycle is visible. Directed runs hold the wait input past the programmed strobe, release it early, and apply it with the wait feature disabled.

// File: rtl/amc_pkg.sv
package amc_pkg;

    localparam int CNT_W = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    // Field order matches the configuration word, bit 31 first.
    typedef struct packed {
        logic       sel_strobe;
        logic       wait_en;
        logic [3:0] wr_setup;
        logic [5:0] wr_strobe;
        logic [2:0] wr_hold;
        logic [3:0] rd_setup;
        logic [5:0] rd_strobe;
        logic [2:0] rd_hold;
        logic [1:0] turn;
        logic [1:0] width;
    } timing_t;

    function automatic logic [CNT_W-1:0] setup_len(timing_t t, logic wr);
        return wr ? CNT_W'(t.wr_setup) : CNT_W'(t.rd_setup);
    endfunction

    function automatic logic [CNT_W-1:0] strobe_len(timing_t t, logic wr);
        return wr ? CNT_W'(t.wr_strobe) : CNT_W'(t.rd_strobe);
    endfunction

    function automatic logic [CNT_W-1:0] hold_len(timing_t t, logic wr);
        return wr ? CNT_W'(t.wr_hold) : CNT_W'(t.rd_hold);
    endfunction

endpackage

// File: rtl/amc_seq.sv
module amc_seq
    import amc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] cfg_word,
    input  logic        mem_wait,
    output logic        req_ready,
    output logic        accept,
    output phase_e      phase,
    output logic        sel_strobe,
    output logic [1:0]  width,
    output logic        is_write,
    output logic        capture,
    output logic        done
);

    phase_e             st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    timing_t            tcfg_q;
    timing_t            req_t;
    logic               wr_q, have_prev_q, done_q;
    logic               cnt_zero, stall, dir_flip;

    assign req_t     = timing_t'(cfg_word);
    assign req_ready = (st_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign cnt_zero  = (cnt_q == '0);
    assign stall     = (st_q == PH_STROBE) && tcfg_q.wait_en && mem_wait;
    assign dir_flip  = have_prev_q && (wr_q != req_write);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            PH_IDLE: begin
                if (accept) begin
                    if (dir_flip) begin
                        st_d  = PH_TURN;
                        cnt_d = CNT_W'(req_t.turn);
                    end else begin
                        st_d  = PH_SETUP;
                        cnt_d = setup_len(req_t, req_write);
                    end
                end
            end
            PH_TURN: begin
                if (cnt_zero) begin
                    st_d  = PH_SETUP;
                    cnt_d = setup_len(tcfg_q, wr_q);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_SETUP: begin
                if (cnt_zero) begin
                    st_d  = PH_STROBE;
                    cnt_d = strobe_len(tcfg_q, wr_q);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_STROBE: begin
                if (cnt_zero && !stall) begin
                    st_d  = PH_HOLD;
                    cnt_d = hold_len(tcfg_q, wr_q);
                end else if (!cnt_zero) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_HOLD: begin
                if (cnt_zero) begin
                    st_d = PH_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= PH_IDLE;
            cnt_q       <= '0;
            tcfg_q      <= '0;
            wr_q        <= 1'b0;
            have_prev_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            done_q <= (st_q == PH_HOLD) && cnt_zero;
            if (accept) begin
                tcfg_q      <= req_t;
                wr_q        <= req_write;
                have_prev_q <= 1'b1;
            end
        end
    end

    assign phase      = st_q;
    assign sel_strobe = tcfg_q.sel_strobe;
    assign width      = tcfg_q.width;
    assign is_write   = wr_q;
    assign capture    = (st_q == PH_STROBE) && cnt_zero && !stall && !wr_q;
    assign done       = done_q;

    // R9: completion is a single pulse that follows the hold phase
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r9_done_after_hold: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(st_q) == PH_HOLD);
    // R3: a phase cannot end before its counter has run out
    a_r3_count_holds_phase: assert property (@(posedge clk) disable iff (rst)
        (st_q != PH_IDLE && !cnt_zero) |=> st_q == $past(st_q));
    // R10: an enabled, asserted wait keeps the strobe phase open
    a_r10_wait_stretches: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_STROBE && tcfg_q.wait_en && mem_wait) |=> st_q == PH_STROBE);

endmodule

// File: rtl/amc_pins.sv
module amc_pins
    import amc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase,
    input  logic              sel_strobe,
    input  logic [1:0]        width,
    input  logic              is_write,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, lane_mask;
    logic              active, strobe;

    generate
        if (DATA_W > 8) begin : g_wide
            assign lane_mask = (width == 2'd0) ? DATA_W'(8'hFF) : '1;
        end else begin : g_narrow
            logic unused_width;
            assign unused_width = ^width;
            assign lane_mask    = '1;
        end
    endgenerate

    assign active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign strobe = (phase == PH_STROBE);

    assign mem_ce_n    = sel_strobe ? !strobe : !active;
    assign mem_oe_n    = !(strobe && !is_write);
    assign mem_we_n    = !(strobe && is_write);
    assign mem_dout_en = active && is_write;
    assign mem_addr    = addr_q;
    assign mem_dout    = wdata_q & lane_mask;
    assign rsp_rdata   = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= mem_din & lane_mask;
            end
        end
    end

    // R6: the two strobes are mutually exclusive
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));
    // R5: chip enable covers every strobe in both styles
    a_r5_ce_covers_strobe: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !mem_ce_n);
    // R8: read capture happens while the output enable is low
    a_r8_capture_in_strobe: assert property (@(posedge clk) disable iff (rst)
        capture |-> !mem_oe_n);
    // R7: data pins are never driven while the device drives them
    a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> mem_oe_n);

endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl
    import amc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [31:0]       cfg_word,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din,
    input  logic              mem_wait
);

    logic       accept, sel_strobe, is_write, capture;
    logic [1:0] width;
    phase_e     phase;

    amc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .cfg_word   (cfg_word),
        .mem_wait   (mem_wait),
        .req_ready  (req_ready),
        .accept     (accept),
        .phase      (phase),
        .sel_strobe (sel_strobe),
        .width      (width),
        .is_write   (is_write),
        .capture    (capture),
        .done       (rsp_done)
    );

    amc_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .phase       (phase),
        .sel_strobe  (sel_strobe),
        .width       (width),
        .is_write    (is_write),
        .capture     (capture),
        .mem_din     (mem_din),
        .mem_ce_n    (mem_ce_n),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_addr    (mem_addr),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en),
        .rsp_rdata   (rsp_rdata)
    );

endmodule

// File: tb/amc_ctrl_tb_top.sv
module amc_ctrl_tb_top;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [31:0]       cfg_word = '0;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_dout, mem_din;
    logic              mem_wait = 1'b0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  have_prev = 0;
    bit  prev_wr = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] pattern(logic [ADDR_W-1:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    // Device model: valid data only while output enable is low
    assign mem_din = !mem_oe_n ? pattern(mem_addr) : 16'hDEAD;

    amc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_word(cfg_word), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_wait(mem_wait)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_access(input logic [31:0] cfg, input bit wr,
                             input logic [ADDR_W-1:0] a, input logic [15:0] d,
                             input int rel);
        int s, t, h, gap, exp_stb;
        int pre_tot = 0, pre_ce = 0, stb = 0, post_tot = 0, post_ce = 0;
        int ce_bad = 0, other_bad = 0, dat_bad = 0, busy = 0;
        bit sel, wen, w8, in_post = 0, wait0, strobe_on, other_on;
        logic [15:0] exp_w, exp_r;
        s   = wr ? int'((cfg >> 26) & 15) : int'((cfg >> 13) & 15);
        t   = wr ? int'((cfg >> 20) & 63) : int'((cfg >> 7) & 63);
        h   = wr ? int'((cfg >> 17) & 7)  : int'((cfg >> 4) & 7);
        sel = cfg[31];
        wen = cfg[30];
        w8  = (cfg[1:0] == 2'd0);
        wait0 = mem_wait;
        exp_stb = (wen && wait0 && rel > t + 1) ? rel : t + 1;
        gap   = (have_prev && prev_wr != wr) ? int'((cfg >> 2) & 3) + 1 : 0;
        exp_w = w8 ? (d & 16'h00FF) : d;
        exp_r = w8 ? (pattern(a) & 16'h00FF) : pattern(a);

        cfg_word  = cfg;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_valid = 1'b1;
        chk("R9 ready before request", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 1000; n++) begin
            if (rsp_done) break;
            if (req_ready) busy++;
            strobe_on = wr ? !mem_we_n : !mem_oe_n;
            other_on  = wr ? !mem_oe_n : !mem_we_n;
            if (other_on) other_bad++;
            if (!wr && mem_dout_en) dat_bad++;
            if (wr && !mem_ce_n && !sel && !mem_dout_en) dat_bad++;
            if (strobe_on) begin
                in_post = 1;
                stb++;
                if (mem_ce_n) ce_bad++;
                if (mem_addr != a) dat_bad++;
                if (wr && (!mem_dout_en || mem_dout != exp_w)) dat_bad++;
                if (wen && rel > 0 && stb == rel) mem_wait = 1'b0;
            end else if (!in_post) begin
                pre_tot++;
                if (!mem_ce_n) pre_ce++;
            end else begin
                post_tot++;
                if (!mem_ce_n) post_ce++;
            end
            @(negedge clk);
        end
        chk("R4 gap plus setup cycles", pre_tot, gap + s + 1);
        chk("R3 setup cycles with ce (R5)", pre_ce, sel ? 0 : s + 1);
        chk("R3 strobe cycles (R10)", stb, exp_stb);
        chk("R3 hold cycles", post_tot, h + 1);
        chk("R5 hold cycles with ce", post_ce, sel ? 0 : h + 1);
        chk("R5 ce low in strobe", ce_bad, 0);
        chk("R6 opposite strobe stays high", other_bad, 0);
        chk("R7 address and data bus", dat_bad, 0);
        chk("R9 ready low while busy", busy, 0);
        chk("R9 done seen", int'(rsp_done), 1);
        chk("R9 ready with done", int'(req_ready), 1);
        if (!wr) chk("R8 read data", int'(rsp_rdata), int'(exp_r));
        @(negedge clk);
        chk("R9 done single pulse", int'(rsp_done), 0);
        have_prev = 1;
        prev_wr   = wr;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] cfg;
        int tw, tr;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ce_n", int'(mem_ce_n), 1);
        chk("R1 oe_n", int'(mem_oe_n), 1);
        chk("R1 we_n", int'(mem_we_n), 1);
        chk("R1 dout_en", int'(mem_dout_en), 0);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 done", int'(rsp_done), 0);

        // R2..R9 sweep: read fields differ from write fields
        for (int i = 0; i < 16; i++) begin
            for (int ti = 0; ti < 3; ti++) begin
                for (int h = 0; h < 8; h++) begin
                    tw = (ti == 0) ? 0 : (ti == 1) ? 2 : 63;
                    tr = (ti == 0) ? 1 : (ti == 1) ? 0 : 40;
                    cfg = (32'(ti == 1) << 31) | (32'(i) << 26) | (32'(tw) << 20)
                        | (32'(h) << 17) | (32'(15 - i) << 13) | (32'(tr) << 7)
                        | (32'(7 - h) << 4) | (32'(i % 4) << 2) | 32'(h % 2);
                    do_access(cfg, 1'b1, ADDR_W'(i * 4099 + h), 16'(16'hA5F0 + i * 17 + h), 0);
                    do_access(cfg, 1'b1, ADDR_W'(i * 77 + h * 3), 16'(16'h1357 ^ (h << 9)), 0);
                    do_access(cfg, 1'b0, ADDR_W'(i * 811 + h * 5), 16'h0, 0);
                    do_access(cfg, 1'b0, ADDR_W'(20'hF0F00 + i + h), 16'h0, 0);
                end
            end
        end

        // R10 wait stretches a read strobe of 2 cycles to 5
        cfg = (32'd1 << 30) | (32'd2 << 26) | (32'd3 << 20) | (32'd1 << 17)
            | (32'd1 << 13) | (32'd1 << 7) | (32'd2 << 4) | (32'd3 << 2) | 32'd1;
        mem_wait = 1'b1;
        do_access(cfg, 1'b0, 20'h12345, 16'h0, 5);
        // R10 wait stretches a write strobe of 4 cycles to 9
        mem_wait = 1'b1;
        do_access(cfg, 1'b1, 20'h00ABC, 16'hBEEF, 9);
        // R10 wait released before the programmed strobe ends
        mem_wait = 1'b1;
        do_access(cfg, 1'b1, 20'h00ABD, 16'hCAFE, 1);
        // R10 wait has no effect while disabled
        cfg[30] = 1'b0;
        mem_wait = 1'b1;
        do_access(cfg, 1'b0, 20'h54321, 16'h0, 0);
        do_access(cfg, 1'b1, 20'h54322, 16'h7E81, 0);
        mem_wait = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule